// File: doc/BRIEF.md
# Flash Serial Clock and Select Timing Generator

This block produces the serial clock and the four select lines for a serial flash port, working entirely in reference-clock cycles. A transfer engine asks for clocks by holding `go` high. The block then does four things in order: it drives the select lines active, waits a programmed lead time, and toggles the serial clock with a half period of `div_sel`+1 reference cycles. It stops at the end of the first full clock period during which `go` has dropped. After a programmed tail time it releases the select lines. It also pulses `launch_stb` and `capture_stb` on each clock edge, according to the phase setting, so the data path knows when to shift and when to sample.

The minimum time the select lines stay inactive between transfers has two values. One value applies when the next transfer targets the same select pattern as the previous one. A second value applies when the next transfer targets a different device. The select bus is driven in one of two forms: as a one-hot active-low pattern chosen by a device index, or as a raw 4-bit code for an external decoder. All configuration inputs are static and change only while `enable` is low.

Top module: `flash_clk_cs_timing`

## Requirements
- R1: After reset, `sel_n` is 4'b1111, `sclk` equals `cpol`, both strobes are 0, and `idle` is 1 while `go` is low.
- R2: While a transfer runs, successive serial clock edges are `div_sel`+1 reference cycles apart, so the serial period is 2×(`div_sel`+1) reference cycles.
- R3: Whenever `sel_n` is 4'b1111, `sclk` equals `cpol`. The first edge of each clock period leaves that level.
- R4: With `cpha`=0, `capture_stb` pulses in the cycle the leading (first) edge of each period appears and `launch_stb` pulses with the trailing edge. With `cpha`=1 the two are swapped. The two strobes are never high together.
- R5: The first serial clock edge appears exactly `dly_lead`+`div_sel`+2 reference cycles after `sel_n` leaves 4'b1111.
- R6: `go` is sampled in the cycle before each trailing edge. If it is low there, that edge is the last one, and `sel_n` returns to 4'b1111 exactly `dly_tail`+1 cycles after it.
- R7: When the next transfer drives the same select pattern as the last one, `sel_n` stays 4'b1111 for at least `dly_rest`+1 cycles. If `go` is already high when the lines release, it stays 4'b1111 for exactly that many cycles.
- R8: When the next pattern differs from the last one, the same rule applies with `dly_swap` in place of `dly_rest`. The first transfer after reset always counts as a device change.
- R9: With `dec_mode`=0, `dev_sel[1:0]`=i drives `sel_n` to the pattern with only bit i low (0→1110, 1→1101, 2→1011, 3→0111) for the whole transfer.
- R10: With `dec_mode`=1, `sel_n` carries `dev_sel` unchanged for the whole transfer.
- R11: `idle` is 1 exactly when no transfer is active, `go` is low, and at least max(`dly_rest`,`dly_swap`)+1 cycles have passed since the select lines last released.
- R12: `enable` low forces `sel_n` to 4'b1111 and `sclk` to `cpol` one cycle later, aborting any transfer, and no transfer starts while it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low aborts and holds at rest |
| cpol | input | 1 | Serial clock rest level |
| cpha | input | 1 | Phase: selects which edge launches and which captures |
| div_sel | input | 4 | Half-period minus one, in reference cycles |
| dly_lead | input | 8 | Select-active to clock-start delay |
| dly_tail | input | 8 | Last-edge to select-release delay |
| dly_rest | input | 8 | Minimum inactive time, same device |
| dly_swap | input | 8 | Minimum inactive time, device change |
| dec_mode | input | 1 | 1: raw code for external decoder; 0: one-hot active low |
| dev_sel | input | 4 | Device index (low bits) or raw select code |
| go | input | 1 | Transfer request from the engine, held high for more clocks |
| sclk | output | 1 | Serial clock |
| sel_n | output | 4 | Select bus |
| launch_stb | output | 1 | One-cycle pulse on the data-launch edge |
| capture_stb | output | 1 | One-cycle pulse on the data-capture edge |
| idle | output | 1 | All timers expired and nothing pending |

## Verification
The hardest situation to reach is a back-to-back transfer whose inactive gap is set by the delay timer rather than by the engine. Reaching it needs `go` to drop just before a trailing edge, and then rise again in the very cycle the select lines release. The stimulus does this by watching the clock pins after each edge, and by re-raising `go` as soon as `sel_n` reads all ones. The same-device gap and the device-change gap then show up at their exact minimum lengths. The slowest divider with the fastest delays, the mid-transfer abort through `enable`, and the pattern match that chooses between the two gap limits are compared against a behavioural per-cycle model.

// File: rtl/fct_pkg.sv
package fct_pkg;
  typedef enum logic [1:0] {
    ST_REST = 2'd0,
    ST_LEAD = 2'd1,
    ST_RUN  = 2'd2,
    ST_TAIL = 2'd3
  } seq_st_e;
endpackage

// File: rtl/fct_sel_map.sv
module fct_sel_map #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dec_mode,
  input  logic [SEL_W-1:0] dev_sel,
  output logic [SEL_W-1:0] pat
);
  localparam int IDX_W = (SEL_W > 1) ? $clog2(SEL_W) : 1;

  function automatic logic [SEL_W-1:0] onehot_low(input logic [IDX_W-1:0] idx);
    logic [SEL_W-1:0] p;
    for (int i = 0; i < SEL_W; i++) p[i] = (IDX_W'(i) != idx);
    return p;
  endfunction

  always_comb begin
    if (dec_mode) pat = dev_sel;
    else          pat = onehot_low(dev_sel[IDX_W-1:0]);
  end

  // R9
  onehot_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_mode |-> ($countones(pat) == SEL_W - 1));
endmodule

// File: rtl/fct_gap_timer.sv
module fct_gap_timer #(
  parameter int SEL_W = 4,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_evt,
  input  logic             rel_evt,
  input  logic [SEL_W-1:0] pat,
  input  logic [DLY_W-1:0] dly_rest,
  input  logic [DLY_W-1:0] dly_swap,
  output logic             gap_ok,
  output logic             all_clear
);
  localparam logic [DLY_W-1:0] SAT = '1;

  logic [DLY_W-1:0] elapsed;
  logic [SEL_W-1:0] last_pat;
  logic             same_dev;

  function automatic logic [DLY_W-1:0] gap_limit(input logic same,
      input logic [DLY_W-1:0] rest, input logic [DLY_W-1:0] swap);
    return same ? rest : swap;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed  <= SAT;
      last_pat <= '1;
    end else begin
      if (rel_evt)             elapsed <= '0;
      else if (elapsed != SAT) elapsed <= elapsed + 1'b1;
      if (start_evt) last_pat <= pat;
    end
  end

  assign same_dev  = (pat == last_pat);
  assign gap_ok    = (elapsed >= gap_limit(same_dev, dly_rest, dly_swap));
  assign all_clear = (elapsed >= dly_rest) && (elapsed >= dly_swap);

  // R7
  gap_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_evt |=> !start_evt || (dly_rest == '0) || (dly_swap == '0));
endmodule

// File: rtl/fct_seq.sv
module fct_seq
  import fct_pkg::*;
#(
  parameter int SEL_W = 4,
  parameter int DIV_W = 4,
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cpha,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [DLY_W-1:0] dly_lead,
  input  logic [DLY_W-1:0] dly_tail,
  input  logic             go,
  input  logic             gap_ok,
  input  logic [SEL_W-1:0] pat,
  output logic             ph,
  output logic [SEL_W-1:0] sel_q,
  output logic             launch_q,
  output logic             capture_q,
  output logic             start_evt,
  output logic             rel_evt,
  output logic             at_rest
);
  seq_st_e          st;
  logic [DLY_W-1:0] cnt;
  logic             cnt_zero;
  logic [DLY_W-1:0] half_load;

  function automatic logic [DLY_W-1:0] half_reload(input logic [DIV_W-1:0] d);
    return DLY_W'(d);
  endfunction

  assign cnt_zero  = (cnt == '0);
  assign half_load = half_reload(div_sel);
  assign at_rest   = (st == ST_REST);
  assign start_evt = enable && (st == ST_REST) && go && gap_ok;
  assign rel_evt   = (enable && (st == ST_TAIL) && cnt_zero) ||
                     (!enable && (st != ST_REST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_REST;
      cnt       <= '0;
      ph        <= 1'b0;
      sel_q     <= '1;
      launch_q  <= 1'b0;
      capture_q <= 1'b0;
    end else begin
      launch_q  <= 1'b0;
      capture_q <= 1'b0;
      if (!enable) begin
        st    <= ST_REST;
        ph    <= 1'b0;
        sel_q <= '1;
      end else begin
        unique case (st)
          ST_REST: if (start_evt) begin
            st    <= ST_LEAD;
            cnt   <= dly_lead;
            sel_q <= pat;
          end
          ST_LEAD: begin
            if (cnt_zero) begin
              st  <= ST_RUN;
              cnt <= half_load;
            end else cnt <= cnt - 1'b1;
          end
          ST_RUN: begin
            if (cnt_zero) begin
              ph  <= ~ph;
              cnt <= half_load;
              if (!ph) begin
                launch_q  <= cpha;
                capture_q <= ~cpha;
              end else begin
                launch_q  <= ~cpha;
                capture_q <= cpha;
                if (!go) begin
                  st  <= ST_TAIL;
                  cnt <= dly_tail;
                end
              end
            end else cnt <= cnt - 1'b1;
          end
          ST_TAIL: begin
            if (cnt_zero) begin
              st    <= ST_REST;
              sel_q <= '1;
            end else cnt <= cnt - 1'b1;
          end
          default: st <= ST_REST;
        endcase
      end
    end
  end

  // R2
  half_period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && st == ST_RUN && !cnt_zero) |=> $stable(ph));

  // R6
  tail_keeps_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && st == ST_TAIL && !cnt_zero) |=> (sel_q != '1) && !ph);
endmodule

// File: rtl/flash_clk_cs_timing.sv
module flash_clk_cs_timing #(
  parameter int SEL_W = 4,
  parameter int DIV_W = 4,
  parameter int DLY_W = 8
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             cpol,
  input  logic             cpha,
  input  logic [DIV_W-1:0] div_sel,
  input  logic [DLY_W-1:0] dly_lead,
  input  logic [DLY_W-1:0] dly_tail,
  input  logic [DLY_W-1:0] dly_rest,
  input  logic [DLY_W-1:0] dly_swap,
  input  logic             dec_mode,
  input  logic [SEL_W-1:0] dev_sel,
  input  logic             go,
  output logic             sclk,
  output logic [SEL_W-1:0] sel_n,
  output logic             launch_stb,
  output logic             capture_stb,
  output logic             idle
);
  logic [SEL_W-1:0] pat;
  logic             gap_ok, all_clear;
  logic             start_evt, rel_evt, at_rest, ph;

  fct_sel_map #(.SEL_W(SEL_W)) u_map (
    .clk(clk_ref), .rst_n(rst_n), .dec_mode(dec_mode), .dev_sel(dev_sel), .pat(pat)
  );

  fct_gap_timer #(.SEL_W(SEL_W), .DLY_W(DLY_W)) u_gap (
    .clk(clk_ref), .rst_n(rst_n), .start_evt(start_evt), .rel_evt(rel_evt),
    .pat(pat), .dly_rest(dly_rest), .dly_swap(dly_swap),
    .gap_ok(gap_ok), .all_clear(all_clear)
  );

  fct_seq #(.SEL_W(SEL_W), .DIV_W(DIV_W), .DLY_W(DLY_W)) u_seq (
    .clk(clk_ref), .rst_n(rst_n), .enable(enable), .cpha(cpha), .div_sel(div_sel),
    .dly_lead(dly_lead), .dly_tail(dly_tail), .go(go), .gap_ok(gap_ok), .pat(pat),
    .ph(ph), .sel_q(sel_n), .launch_q(launch_stb), .capture_q(capture_stb),
    .start_evt(start_evt), .rel_evt(rel_evt), .at_rest(at_rest)
  );

  assign sclk = cpol ^ ph;
  assign idle = at_rest && !go && all_clear;

  // R3
  rest_level_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (sel_n == '1) |-> (sclk == cpol));

  // R4
  strobe_exclusive_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !(launch_stb && capture_stb));

  // R11
  idle_released_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    idle |-> (sel_n == '1) && !launch_stb && !capture_stb);

  // R12
  disable_rest_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !enable |=> (sel_n == '1));
endmodule

// File: tb/tb_flash_clk_cs_timing.sv
`timescale 1ns/1ps
module tb_flash_clk_cs_timing;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, cpol = 1'b0, cpha = 1'b0, dec_mode = 1'b0, go = 1'b0;
  logic [3:0] div_sel = '0, dev_sel = '0;
  logic [7:0] dly_lead = '0, dly_tail = '0, dly_rest = '0, dly_swap = '0;
  logic sclk, launch_stb, capture_stb, idle;
  logic [3:0] sel_n;

  always #2 clk = ~clk;

  flash_clk_cs_timing dut (
    .clk_ref(clk), .rst_n(rst_n), .enable(enable), .cpol(cpol), .cpha(cpha),
    .div_sel(div_sel), .dly_lead(dly_lead), .dly_tail(dly_tail), .dly_rest(dly_rest),
    .dly_swap(dly_swap), .dec_mode(dec_mode), .dev_sel(dev_sel), .go(go),
    .sclk(sclk), .sel_n(sel_n), .launch_stb(launch_stb), .capture_stb(capture_stb),
    .idle(idle)
  );

  int checks = 0, fails = 0, cyc = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic int want_pat(input logic dm, input logic [3:0] v);
    if (dm) return int'(v);
    return 15 - (1 << v[1:0]);
  endfunction

  // behavioural reference: phase 0 rest, 1 lead wait, 2 clocking, 3 tail wait
  int m_phase = 0, m_left = 0, m_lvl = 0, m_sel = 15, m_l = 0, m_c = 0;
  int m_since = 255, m_prev = 15;
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_phase = 0; m_left = 0; m_lvl = 0; m_sel = 15; m_l = 0; m_c = 0;
      m_since = 255; m_prev = 15;
    end else begin
      int p, need;
      bit released;
      p = want_pat(dec_mode, dev_sel);
      need = (p == m_prev) ? int'(dly_rest) : int'(dly_swap);
      released = 0; m_l = 0; m_c = 0;
      if (!enable) begin
        if (m_phase != 0) released = 1;
        m_phase = 0; m_lvl = 0; m_sel = 15;
      end else if (m_phase == 0) begin
        if (go && m_since >= need) begin
          m_phase = 1; m_left = dly_lead; m_sel = p; m_prev = p;
        end
      end else if (m_phase == 1) begin
        if (m_left == 0) begin m_phase = 2; m_left = div_sel; end
        else m_left--;
      end else if (m_phase == 2) begin
        if (m_left == 0) begin
          m_left = div_sel;
          if (m_lvl == 0) begin m_lvl = 1; m_l = cpha; m_c = !cpha; end
          else begin
            m_lvl = 0; m_l = !cpha; m_c = cpha;
            if (!go) begin m_phase = 3; m_left = dly_tail; end
          end
        end else m_left--;
      end else begin
        if (m_left == 0) begin m_phase = 0; m_sel = 15; released = 1; end
        else m_left--;
      end
      if (released) m_since = 0;
      else if (m_since < 255) m_since++;
    end
  end

  // per-cycle comparison and event timestamps
  int t_fall = 0, t_rise = 0, t_prev_rise = 0, t_first = 0, t_edge = 0, fall_pat = 15;
  bit first_seen = 0;
  logic [3:0] prev_sel = 4'hF;
  logic prev_sclk = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      check("R3/R2 sclk", int'(sclk), int'(cpol) ^ m_lvl);
      check("R9/R10 sel_n", int'(sel_n), m_sel);
      check("R4 launch", int'(launch_stb), m_l);
      check("R4 capture", int'(capture_stb), m_c);
      check("R11 idle", int'(idle),
            int'(m_phase == 0 && !go && m_since >= dly_rest && m_since >= dly_swap));
      if (sel_n != 4'hF && prev_sel == 4'hF) begin
        t_prev_rise = t_rise; t_fall = cyc; first_seen = 0; fall_pat = sel_n;
      end
      if (sclk != prev_sclk && sel_n != 4'hF) begin
        if (!first_seen) begin t_first = cyc; first_seen = 1; end
        else check("R2 edge spacing", cyc - t_edge, int'(div_sel) + 1);
        t_edge = cyc;
      end
      if (sel_n == 4'hF && prev_sel != 4'hF) t_rise = cyc;
    end
    prev_sel = sel_n;
    prev_sclk = sclk;
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic xfer(input logic [3:0] dev, input int nclk);
    int k;
    logic ps;
    k = 0;
    dev_sel = dev;
    go = 1'b1;
    ps = sclk;
    while (k < nclk) begin
      @(posedge clk); #1;
      if (sclk != cpol && ps == cpol) k++;
      ps = sclk;
    end
    go = 1'b0;
    do begin @(posedge clk); #1; end while (sel_n != 4'hF);
    @(negedge clk); #0.5;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #0.5;
    // R1
    check("R1 sel_n", int'(sel_n), 15);
    check("R1 sclk", int'(sclk), 0);
    check("R1 strobes", int'(launch_stb | capture_stb), 0);
    check("R1 idle", int'(idle), 1);

    div_sel = 4'd0; dly_lead = 8'd2; dly_tail = 8'd3; dly_rest = 8'd4; dly_swap = 8'd9;
    enable = 1'b1;
    xfer(4'd1, 3);
    check("R9 one-hot dev1", fall_pat, 4'b1101);
    check("R5 lead", t_first - t_fall, 2 + 0 + 2);
    check("R6 tail", t_rise - t_edge, 3 + 1);
    xfer(4'd1, 2);
    check("R7 same-device gap", t_fall - t_prev_rise, 4 + 1);
    xfer(4'd2, 1);
    check("R8 device-change gap", t_fall - t_prev_rise, 9 + 1);
    check("R9 one-hot dev2", fall_pat, 4'b1011);
    xfer(4'd3, 1);
    check("R9 one-hot dev3", fall_pat, 4'b0111);

    @(posedge clk); #1 enable = 1'b0;
    @(posedge clk); #1;
    div_sel = 4'd3; cpol = 1'b1; cpha = 1'b1; dec_mode = 1'b1;
    dly_lead = 8'd0; dly_tail = 8'd0; dly_rest = 8'd0; dly_swap = 8'd1;
    @(posedge clk); #1 enable = 1'b1;
    @(negedge clk); #0.5;
    check("R3 rest level high", int'(sclk), 1);
    xfer(4'b0101, 2);
    check("R10 decoded", fall_pat, 4'b0101);
    check("R5 lead slow", t_first - t_fall, 0 + 3 + 2);
    check("R6 tail zero", t_rise - t_edge, 1);
    xfer(4'b0101, 1);
    check("R7 zero gap", t_fall - t_prev_rise, 1);
    xfer(4'b1010, 1);
    check("R8 swap gap", t_fall - t_prev_rise, 2);

    // R12: abort mid-transfer and hold off while disabled
    dev_sel = 4'b0011; go = 1'b1;
    do begin @(posedge clk); #1; end while (sclk == cpol);
    enable = 1'b0;
    @(posedge clk); @(negedge clk); #0.5;
    check("R12 abort sel_n", int'(sel_n), 15);
    check("R12 abort sclk", int'(sclk), int'(cpol));
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #0.5;
      check("R12 held off", int'(sel_n), 15);
    end
    go = 1'b0;
    @(posedge clk); #1 enable = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); #0.5;
    check("R11 idle settles", int'(idle), 1);
    go = 1'b1;
    @(negedge clk); #0.5;
    check("R11 pending request", int'(idle), 0);
    go = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #0.5;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule